// File: doc/BRIEF.md
# Configurable Address-Line Register Decoder

This block sits between the CPU write bus and a banking and interrupt controller whose register ports are picked by two select inputs. On the board those two inputs may be wired to any two adjacent low CPU address lines, in either order. A 4-bit configuration code describes that wiring. The block turns each CPU write into a registered, one-cycle strobe that carries the register group (address bits 15..12), the 2-bit port index inside that group, a one-hot group strobe, and a dedicated strobe for each of the four interrupt ports.

Bits 2:0 of the code name the address line that drives the low select input. Bit 3 says whether the high select input comes from the next higher line (1) or the next lower line (0). Code 0 would need a line below A0, so it is flagged as an error and every strobe is blocked. Code 15 would need a line above A7, so it is reused to pick a simpler legacy controller. That controller has no interrupts, decodes A0 as the low select and A1 as the high select, and holds a one-bit latch written in the 0x6000..0x6FFF region.

Top module: `addr_line_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, the edge clears wr_stb, wr_group, wr_port, grp_stb, all four interrupt strobes and legacy_bit to 0.
- R2: For a code other than 0 and 15, the low select line is A[code[2:0]]. The high select line is A[code[2:0]+1] if code[3]=1 and A[code[2:0]-1] otherwise. wr_port = {high line, low line}, so with code 9 the offsets 0, 2, 4 and 6 give ports 0, 1, 2 and 3.
- R3: Code 14 maps offsets 0x00, 0x40, 0x80 and 0xC0 to ports 0..3. Code 1 maps offsets 0, 2, 1 and 3 to ports 0..3. Code 3 maps offsets 0, 8, 4 and 0xC to ports 0..3.
- R4: A write sampled with cpu_wr=1 at clock edge N, to an address in 0x8000..0xFFFF with a valid code, sets wr_stb for exactly the cycle after edge N. In that cycle wr_group = address bits 15..12, and grp_stb bit (group-8) is the only bit set. A write below 0x8000 produces no wr_stb. Outside a strobe, wr_group, wr_port and grp_stb are 0.
- R5: With code 0, cfg_err is 1 and a write produces no strobe of any kind and leaves legacy_bit unchanged. With any other code, cfg_err is 0.
- R6: A strobed write to group 0xF with a code other than 15 also raises exactly one interrupt strobe, chosen by port: 0 = latch low, 1 = latch high, 2 = control, 3 = acknowledge.
- R7: With code 15, legacy_mode is 1, the port index is {A1, A0}, group strobes still fire, and no interrupt strobe ever fires. With other codes, legacy_mode is 0.
- R8: With code 15, a write to 0x6000..0x6FFF loads cpu_data bit 0 into legacy_bit after the edge and raises no wr_stb. With any other code, such a write leaves legacy_bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_code | input | 4 | Wiring code for the port-select lines |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data (bit 0 feeds the legacy latch) |
| cpu_wr | input | 1 | High for one clock per CPU write |
| cfg_err | output | 1 | Code 0 is selected |
| legacy_mode | output | 1 | Code 15 is selected |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_group | output | 4 | Group of the strobed write |
| wr_port | output | 2 | Port index of the strobed write |
| grp_stb | output | 8 | One-hot strobe, bit i is group 8+i |
| irq_lat_lo_stb | output | 1 | Interrupt latch low port written |
| irq_lat_hi_stb | output | 1 | Interrupt latch high port written |
| irq_ctl_stb | output | 1 | Interrupt control port written |
| irq_ack_stb | output | 1 | Interrupt acknowledge port written |
| legacy_bit | output | 1 | Legacy single-bit latch |

## Verification
The assertions check the following on every cycle:
- Each strobe follows a sampled write and carries that write's group.
- The group strobe and the interrupt strobes are one-hot or zero.
- An interrupt strobe appears only with a group-0xF write strobe.
- Code 0 blocks all strobes and holds the latch.
- Code 15 never raises an interrupt strobe.

The mapping from address offsets to port numbers for each wiring code can only be shown by the bench's scenarios, because it depends on the code in use. The same holds for the legacy latch data path and for the release from reset.

// File: rtl/addr_line_decoder_pkg.sv
// Package: shared codes and types for the configurable address-line decoder.
// Assumes a 4-bit wiring code and a 2-bit port index.
package addr_line_decoder_pkg;

    // Codes that cannot describe a real pair of adjacent lines
    localparam logic [3:0] CODE_INVALID = 4'd0;
    localparam logic [3:0] CODE_LEGACY  = 4'd15;

    // Port roles inside the interrupt group, by port index
    typedef enum logic [1:0] {
        IRQ_PORT_LAT_LO = 2'd0,
        IRQ_PORT_LAT_HI = 2'd1,
        IRQ_PORT_CTL    = 2'd2,
        IRQ_PORT_ACK    = 2'd3
    } irq_port_e;

    // Decoded wiring description
    typedef struct packed {
        logic [2:0] lo_line;
        logic [2:0] hi_line;
        logic       valid;
        logic       legacy;
    } line_sel_t;

endpackage

// File: rtl/adl_line_select.sv
// Module: adl_line_select
// Turns the 4-bit wiring code into the indices of the address lines that
// drive the low and high port-select inputs. It also flags the invalid code
// and the legacy code.
// Assumes: the lines are among A7..A0. The legacy lines are set by parameters.
module adl_line_select
    import addr_line_decoder_pkg::*;
#(
    parameter int LEGACY_LO_LINE = 0,
    parameter int LEGACY_HI_LINE = 1
) (
    input  logic [3:0] cfg_code,
    output line_sel_t  sel
);

    localparam logic [2:0] LEG_LO = 3'(LEGACY_LO_LINE);
    localparam logic [2:0] LEG_HI = 3'(LEGACY_HI_LINE);

    // Decode the code into line indices and mode flags
    always_comb begin
        sel.valid  = (cfg_code != CODE_INVALID);
        sel.legacy = (cfg_code == CODE_LEGACY);
        if (sel.legacy) begin
            sel.lo_line = LEG_LO;
            sel.hi_line = LEG_HI;
        end else begin
            sel.lo_line = cfg_code[2:0];
            sel.hi_line = cfg_code[3] ? (cfg_code[2:0] + 3'd1)
                                      : (cfg_code[2:0] - 3'd1);
        end
    end

endmodule

// File: rtl/adl_port_extract.sv
// Module: adl_port_extract
// Picks the two selected address lines out of the low address bits and
// forms the port index {high, low}.
// Assumes: the line indices are below SEL_LINES.
module adl_port_extract #(
    parameter int SEL_LINES = 8,
    localparam int IDX_W = $clog2(SEL_LINES)
) (
    input  logic [SEL_LINES-1:0] addr_low,
    input  logic [IDX_W-1:0]     lo_line,
    input  logic [IDX_W-1:0]     hi_line,
    output logic [1:0]           port
);

    logic [SEL_LINES-1:0] lo_hit;
    logic [SEL_LINES-1:0] hi_hit;

    // One AND term per line for each select input, merged by OR below
    for (genvar i = 0; i < SEL_LINES; i++) begin : g_line
        assign lo_hit[i] = addr_low[i] && (lo_line == IDX_W'(i));
        assign hi_hit[i] = addr_low[i] && (hi_line == IDX_W'(i));
    end

    // Merge the one-line hits into the port index
    always_comb begin
        port = {|hi_hit, |lo_hit};
    end

endmodule

// File: rtl/adl_strobe_gen.sv
// Module: adl_strobe_gen
// Registers one write cycle into the group, port, group-strobe and
// interrupt-strobe outputs, and keeps the legacy single-bit latch.
// Assumes: cpu_wr is high for one clock per write. Reset is synchronous
// and active low.
module adl_strobe_gen
    import addr_line_decoder_pkg::*;
#(
    parameter int GRP_W          = 4,
    parameter int REG_BASE_GROUP = 8,
    parameter int IRQ_GROUP      = 15,
    parameter int LEGACY_GROUP   = 6,
    localparam int NUM_REG_GRP   = (1 << GRP_W) - REG_BASE_GROUP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [GRP_W-1:0]       group,
    input  logic [1:0]             port,
    input  logic                   data_bit,
    input  logic                   valid,
    input  logic                   legacy,
    output logic                   wr_stb,
    output logic [GRP_W-1:0]       wr_group,
    output logic [1:0]             wr_port,
    output logic [NUM_REG_GRP-1:0] grp_stb,
    output logic [3:0]             irq_stb,
    output logic                   legacy_bit
);

    localparam logic [GRP_W-1:0] BASE_G = GRP_W'(REG_BASE_GROUP);
    localparam logic [GRP_W-1:0] IRQ_G  = GRP_W'(IRQ_GROUP);
    localparam logic [GRP_W-1:0] LEG_G  = GRP_W'(LEGACY_GROUP);

    logic [NUM_REG_GRP-1:0] grp_hit;
    logic                   reg_hit;
    logic                   irq_hit;
    logic                   latch_hit;

    // One comparator per register group
    for (genvar g = 0; g < NUM_REG_GRP; g++) begin : g_grp
        assign grp_hit[g] = (group == GRP_W'(REG_BASE_GROUP + g));
    end

    // Classify the current write
    always_comb begin
        reg_hit   = wr && valid && (group >= BASE_G);
        irq_hit   = reg_hit && !legacy && (group == IRQ_G);
        latch_hit = wr && valid && legacy && (group == LEG_G);
    end

    // Register the strobes; each lasts exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb   <= 1'b0;
            wr_group <= '0;
            wr_port  <= '0;
            grp_stb  <= '0;
            irq_stb  <= '0;
        end else begin
            wr_stb   <= reg_hit;
            wr_group <= reg_hit ? group : '0;
            wr_port  <= reg_hit ? port : '0;
            grp_stb  <= reg_hit ? grp_hit : '0;
            irq_stb  <= irq_hit ? (4'b0001 << port) : 4'b0000;
        end
    end

    // Legacy single-bit latch, loaded only in legacy mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legacy_bit <= 1'b0;
        end else if (latch_hit) begin
            legacy_bit <= data_bit;
        end
    end

endmodule

// File: rtl/addr_line_decoder.sv
// Module: addr_line_decoder (top)
// Decodes CPU writes into register-port strobes for a banking and interrupt
// controller whose two port-select inputs sit on any adjacent pair of low
// address lines chosen by cfg_code.
// Assumes: cfg_code is static during normal use. The outputs follow a write
// by one clock.
module addr_line_decoder
    import addr_line_decoder_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 8,
    parameter int GRP_W          = 4,
    parameter int SEL_LINES      = 8,
    parameter int REG_BASE_GROUP = 8,
    parameter int IRQ_GROUP      = 15,
    parameter int LEGACY_GROUP   = 6,
    parameter int LEGACY_LO_LINE = 0,
    parameter int LEGACY_HI_LINE = 1,
    localparam int NUM_REG_GRP   = (1 << GRP_W) - REG_BASE_GROUP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             cfg_code,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [DATA_W-1:0]      cpu_data,
    input  logic                   cpu_wr,
    output logic                   cfg_err,
    output logic                   legacy_mode,
    output logic                   wr_stb,
    output logic [GRP_W-1:0]       wr_group,
    output logic [1:0]             wr_port,
    output logic [NUM_REG_GRP-1:0] grp_stb,
    output logic                   irq_lat_lo_stb,
    output logic                   irq_lat_hi_stb,
    output logic                   irq_ctl_stb,
    output logic                   irq_ack_stb,
    output logic                   legacy_bit
);

    line_sel_t        sel;
    logic [1:0]       port;
    logic [3:0]       irq_stb;
    logic [GRP_W-1:0] group;
    logic             unused_bits;

    // Bits the decoder does not look at
    assign unused_bits = ^{cpu_data[DATA_W-1:1], cpu_addr[ADDR_W-GRP_W-1:SEL_LINES]};
    assign group       = cpu_addr[ADDR_W-1 -: GRP_W];

    adl_line_select #(
        .LEGACY_LO_LINE (LEGACY_LO_LINE),
        .LEGACY_HI_LINE (LEGACY_HI_LINE)
    ) u_line_select (
        .cfg_code (cfg_code),
        .sel      (sel)
    );

    adl_port_extract #(
        .SEL_LINES (SEL_LINES)
    ) u_port_extract (
        .addr_low (cpu_addr[SEL_LINES-1:0]),
        .lo_line  (sel.lo_line),
        .hi_line  (sel.hi_line),
        .port     (port)
    );

    adl_strobe_gen #(
        .GRP_W          (GRP_W),
        .REG_BASE_GROUP (REG_BASE_GROUP),
        .IRQ_GROUP      (IRQ_GROUP),
        .LEGACY_GROUP   (LEGACY_GROUP)
    ) u_strobe_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cpu_wr),
        .group      (group),
        .port       (port),
        .data_bit   (cpu_data[0]),
        .valid      (sel.valid),
        .legacy     (sel.legacy),
        .wr_stb     (wr_stb),
        .wr_group   (wr_group),
        .wr_port    (wr_port),
        .grp_stb    (grp_stb),
        .irq_stb    (irq_stb),
        .legacy_bit (legacy_bit)
    );

    // Mode flags and the named interrupt strobes
    always_comb begin
        cfg_err        = !sel.valid;
        legacy_mode    = sel.legacy;
        irq_lat_lo_stb = irq_stb[IRQ_PORT_LAT_LO];
        irq_lat_hi_stb = irq_stb[IRQ_PORT_LAT_HI];
        irq_ctl_stb    = irq_stb[IRQ_PORT_CTL];
        irq_ack_stb    = irq_stb[IRQ_PORT_ACK];
    end

endmodule

// File: rtl/addr_line_decoder_chk.sv
// Module: addr_line_decoder_chk
// Checker for the decoder's port-level rules, attached by bind below.
// Assumes: the same group parameters as the decoder instance.
module addr_line_decoder_chk #(
    parameter int GRP_W          = 4,
    parameter int REG_BASE_GROUP = 8,
    parameter int IRQ_GROUP      = 15,
    localparam int NUM_REG_GRP   = (1 << GRP_W) - REG_BASE_GROUP
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0]             cfg_code,
    input logic [15:0]            cpu_addr,
    input logic                   cpu_wr,
    input logic                   wr_stb,
    input logic [GRP_W-1:0]       wr_group,
    input logic [NUM_REG_GRP-1:0] grp_stb,
    input logic                   irq_lat_lo_stb,
    input logic                   irq_lat_hi_stb,
    input logic                   irq_ctl_stb,
    input logic                   irq_ack_stb,
    input logic                   legacy_bit
);

    logic [3:0] irq_all;
    assign irq_all = {irq_ack_stb, irq_ctl_stb, irq_lat_hi_stb, irq_lat_lo_stb};

    // R4
    stb_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(cpu_wr) && (wr_group == $past(cpu_addr[15:12]))));

    // R4
    grp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_stb) && (wr_stb == (|grp_stb)));

    // R6
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_all));

    // R6
    irq_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_all) |-> (wr_stb && (wr_group == GRP_W'(IRQ_GROUP))));

    // R5
    invalid_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_code) == 4'd0) |-> (!wr_stb && (irq_all == 4'b0000) && $stable(legacy_bit)));

    // R7
    legacy_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_code) == 4'd15) |-> (irq_all == 4'b0000));

endmodule

bind addr_line_decoder addr_line_decoder_chk #(
    .GRP_W          (GRP_W),
    .REG_BASE_GROUP (REG_BASE_GROUP),
    .IRQ_GROUP      (IRQ_GROUP)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_code       (cfg_code),
    .cpu_addr       (cpu_addr),
    .cpu_wr         (cpu_wr),
    .wr_stb         (wr_stb),
    .wr_group       (wr_group),
    .grp_stb        (grp_stb),
    .irq_lat_lo_stb (irq_lat_lo_stb),
    .irq_lat_hi_stb (irq_lat_hi_stb),
    .irq_ctl_stb    (irq_ctl_stb),
    .irq_ack_stb    (irq_ack_stb),
    .legacy_bit     (legacy_bit)
);

// File: tb/addr_line_decoder_bench.sv
// Bench for addr_line_decoder: a vector table walked by one loop, then
// directed tests for reset, legacy latch, error code and pulse width.
module addr_line_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [3:0]  cfg;
        logic [15:0] addr;
        logic [1:0]  port;
        logic        stb;
    } vec_t;

    localparam int NVEC = 25;
    localparam vec_t VEC [NVEC] = '{
        '{4'd9,  16'hF000, 2'd0, 1'b1}, '{4'd9,  16'hF002, 2'd1, 1'b1},
        '{4'd9,  16'hF004, 2'd2, 1'b1}, '{4'd9,  16'hF006, 2'd3, 1'b1},
        '{4'd14, 16'h8000, 2'd0, 1'b1}, '{4'd14, 16'h8040, 2'd1, 1'b1},
        '{4'd14, 16'h8080, 2'd2, 1'b1}, '{4'd14, 16'h80C0, 2'd3, 1'b1},
        '{4'd1,  16'h9000, 2'd0, 1'b1}, '{4'd1,  16'h9002, 2'd1, 1'b1},
        '{4'd1,  16'h9001, 2'd2, 1'b1}, '{4'd1,  16'h9003, 2'd3, 1'b1},
        '{4'd3,  16'hF000, 2'd0, 1'b1}, '{4'd3,  16'hF008, 2'd1, 1'b1},
        '{4'd3,  16'hF004, 2'd2, 1'b1}, '{4'd3,  16'hF00C, 2'd3, 1'b1},
        '{4'd10, 16'hB004, 2'd1, 1'b1}, '{4'd10, 16'hB008, 2'd2, 1'b1},
        '{4'd8,  16'hC003, 2'd3, 1'b1},
        '{4'd7,  16'hD080, 2'd1, 1'b1}, '{4'd7,  16'hD040, 2'd2, 1'b1},
        '{4'd15, 16'hF001, 2'd1, 1'b1}, '{4'd15, 16'hE002, 2'd2, 1'b1},
        '{4'd0,  16'hF006, 2'd0, 1'b0},
        '{4'd9,  16'h7006, 2'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_code = 4'd9;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic        cfg_err, legacy_mode, wr_stb, legacy_bit;
    logic [3:0]  wr_group;
    logic [1:0]  wr_port;
    logic [7:0]  grp_stb;
    logic        irq_lat_lo_stb, irq_lat_hi_stb, irq_ctl_stb, irq_ack_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_line_decoder u_addr_line_decoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_code       (cfg_code),
        .cpu_addr       (cpu_addr),
        .cpu_data       (cpu_data),
        .cpu_wr         (cpu_wr),
        .cfg_err        (cfg_err),
        .legacy_mode    (legacy_mode),
        .wr_stb         (wr_stb),
        .wr_group       (wr_group),
        .wr_port        (wr_port),
        .grp_stb        (grp_stb),
        .irq_lat_lo_stb (irq_lat_lo_stb),
        .irq_lat_hi_stb (irq_lat_hi_stb),
        .irq_ctl_stb    (irq_ctl_stb),
        .irq_ack_stb    (irq_ack_stb),
        .legacy_bit     (legacy_bit)
    );

    function automatic logic [3:0] irq_vec();
        return {irq_ack_stb, irq_ctl_stb, irq_lat_hi_stb, irq_lat_lo_stb};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One write cycle; returns at the next falling edge with outputs settled
    task automatic do_write(input logic [3:0] c, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_code = c;
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
    endtask

    function automatic string tag_of(input logic [3:0] c, input logic [15:0] a);
        if (c == 4'd0)  return "R5";
        if (c == 4'd15) return "R7";
        if (a < 16'h8000) return "R4";
        if (c == 4'd14 || c == 4'd1 || c == 4'd3) return "R3";
        return "R2";
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [3:0] exp_irq;
        logic [7:0] exp_grp;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "wr_stb", wr_stb, 0);
        chk("R1", "grp_stb", grp_stb, 0);
        chk("R1", "irq", irq_vec(), 0);
        chk("R1", "legacy_bit", legacy_bit, 0);
        chk("R1", "wr_group", wr_group, 0);
        rst_n = 1'b1;

        // Vector table walk: R2, R3, R4, R5, R6, R7
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i].cfg, VEC[i].addr, 8'h00);
            exp_irq = (VEC[i].stb && VEC[i].addr[15:12] == 4'hF && VEC[i].cfg != 4'd15)
                      ? (4'b0001 << VEC[i].port) : 4'b0000;
            exp_grp = VEC[i].stb ? (8'b1 << (VEC[i].addr[15:12] - 4'd8)) : 8'b0;
            chk(tag_of(VEC[i].cfg, VEC[i].addr), $sformatf("vec %0d wr_stb", i), wr_stb, VEC[i].stb);
            chk(tag_of(VEC[i].cfg, VEC[i].addr), $sformatf("vec %0d wr_port", i), wr_port,
                VEC[i].stb ? VEC[i].port : 2'd0);
            chk(tag_of(VEC[i].cfg, VEC[i].addr), $sformatf("vec %0d wr_group", i), wr_group,
                VEC[i].stb ? VEC[i].addr[15:12] : 4'd0);
            chk("R4", $sformatf("vec %0d grp_stb", i), grp_stb, exp_grp);
            chk("R6", $sformatf("vec %0d irq", i), irq_vec(), exp_irq);
        end

        // R4: strobe lasts one cycle
        do_write(4'd9, 16'hA002, 8'h00);
        chk("R4", "pulse high", wr_stb, 1);
        @(negedge clk);
        chk("R4", "pulse low next cycle", wr_stb, 0);
        chk("R4", "grp low next cycle", grp_stb, 0);

        // R5 / R7: mode flags
        cfg_code = 4'd0;
        #1 chk("R5", "cfg_err code 0", cfg_err, 1);
        cfg_code = 4'd15;
        #1 chk("R7", "legacy_mode code 15", legacy_mode, 1);
        chk("R5", "cfg_err code 15", cfg_err, 0);
        cfg_code = 4'd9;
        #1 chk("R7", "legacy_mode code 9", legacy_mode, 0);

        // R8: legacy latch loads in legacy mode only
        do_write(4'd15, 16'h6000, 8'h01);
        chk("R8", "latch set", legacy_bit, 1);
        chk("R8", "no strobe on latch", wr_stb, 0);
        do_write(4'd9, 16'h6FFF, 8'h00);
        chk("R8", "latch held code 9", legacy_bit, 1);
        do_write(4'd0, 16'h6000, 8'h00);
        chk("R5", "latch held code 0", legacy_bit, 1);
        do_write(4'd15, 16'h6ABC, 8'hFE);
        chk("R8", "latch cleared", legacy_bit, 0);

        // R7: legacy acknowledge-like offset gives no interrupt strobe
        do_write(4'd15, 16'hF003, 8'h00);
        chk("R7", "legacy port", wr_port, 3);
        chk("R7", "legacy irq", irq_vec(), 0);

        // R6: acknowledge port with code 9
        do_write(4'd9, 16'hF006, 8'h00);
        chk("R6", "ack strobe", irq_ack_stb, 1);

        // R1: reset clears latch and strobes
        do_write(4'd15, 16'h6000, 8'h01);
        @(negedge clk);
        cfg_code = 4'd9;
        cpu_addr = 16'hF000;
        cpu_wr   = 1'b1;
        rst_n    = 1'b0;
        @(negedge clk);
        cpu_wr   = 1'b0;
        chk("R1", "latch after reset", legacy_bit, 0);
        chk("R1", "stb after reset", wr_stb, 0);
        chk("R1", "irq after reset", irq_vec(), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule